// File: doc/BRIEF.md
# Multichannel 2D block DMA

This block copies rectangular blocks of words between regions of a single memory on behalf of several independent channels. A block is given by a start address, a row width, a row count and a skip: the number of words left out between the end of one row and the start of the next in the source. The engine reads only the words inside the block and writes them to the destination as one dense run, so the output has no gaps and no word outside the block is ever fetched.

Software loads a descriptor into a channel through a small write-only register port and then issues a go command. The channel then runs with no further help. All active channels share one memory port. A round-robin arbiter grants it one burst at a time. Each burst reads up to eight words into a staging buffer and then writes them out. A go command sent while a channel is still busy queues the new descriptor, so work can be chained. When the final descriptor finishes, the channel drops its busy flag and raises a sticky done flag, which also drives the interrupt line.

Top module: `dma2d_top`

## Requirements
- R1: After reset the memory port is idle (`mem_req` low), and all busy flags, all done flags and `irq` are low.
- R2: For a block with source `S`, width `W`, height `H` and skip `K`, the source words read are `S + r*(W+K) + c`. Rows are taken in ascending order `r`, and within a row the columns go in ascending order `c`.
- R3: The word read from source row `r`, column `c` is written to `D + r*W + c`, where `D` is the destination. The destination therefore holds the block packed with no gaps.
- R4: One grant moves between 1 and 8 words and never crosses the end of a source row. All reads of a burst are issued before any of its writes, so a row of width 10 takes two bursts of 8 and 2.
- R5: When several channels have work, grants rotate round-robin. The search starts at the channel after the last one served.
- R6: When a channel's last row completes and nothing is queued, its busy flag clears and its done flag sets, and `irq` goes high. An ack command clears done, and `irq` falls once no done flag remains.
- R7: A descriptor with width 0 or height 0 completes and sets done without making a single memory request.
- R8: A go command sent to a busy channel queues the descriptor fields held at that moment. The channel moves on to the queued descriptor when the current one ends, and done stays low until the queued descriptor has also finished.
- R9: Register writes select a field with `cfg_fld`: 0 source address, 1 destination address, 2 width, 3 height, 4 skip, 5 go, 6 ack. Width, height and skip take the low `LW` bits of `cfg_wdata`.
- R10: Memory read data is taken from `mem_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | $clog2(NCH) | Channel addressed by the write |
| cfg_fld | input | 3 | Field or command selector |
| cfg_wdata | input | AW | Write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| ch_busy | output | NCH | Channel running a descriptor |
| ch_done | output | NCH | Sticky completion flag per channel |
| irq | output | 1 | High while any done flag is set |

## Verification
The main function is tried with several block shapes. A strided block whose width of 10 is not a multiple of the burst shows whether row stepping, skip handling and the split into bursts are correct. Single-column blocks and blocks with no skip show whether packed addressing has off-by-one errors at the edges. Two channels started back to back, with three bursts each, must produce strictly alternating bursts, which separates true rotation from fixed priority. Zero-sized and chained descriptors check that completion needs no memory traffic and that done is held back until the queued descriptor ends. Every destination write is matched against a per-channel scoreboard, so channels that run at the same time cannot hide a misordered or misrouted word.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [2:0] {
    FLD_SRC = 3'd0,
    FLD_DST = 3'd1,
    FLD_WID = 3'd2,
    FLD_HGT = 3'd3,
    FLD_SKP = 3'd4,
    FLD_GO  = 3'd5,
    FLD_ACK = 3'd6
  } fld_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_DRAIN = 3'd2,
    ST_WR    = 3'd3,
    ST_ADV   = 3'd4
  } eng_st_e;

endpackage

// File: rtl/dma2d_chan.sv
module dma2d_chan
  import dma2d_pkg::*;
#(
  parameter int AW  = 16,
  parameter int LW  = 8,
  parameter int BLW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          adv,
  input  logic [BLW-1:0] adv_len,
  output logic          req,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] row_rem,
  output logic          busy,
  output logic          done
);

  // queued descriptor
  logic [AW-1:0] nx_src_q, nx_src_d, nx_dst_q, nx_dst_d;
  logic [LW-1:0] nx_w_q, nx_w_d, nx_h_q, nx_h_d, nx_k_q, nx_k_d;
  logic          pend_q, pend_d;
  // active descriptor
  logic [AW-1:0] a_row_q, a_row_d, a_dst_q, a_dst_d;
  logic [LW-1:0] a_w_q, a_w_d, a_k_q, a_k_d, a_col_q, a_col_d, a_rows_q, a_rows_d;
  logic          busy_q, busy_d, done_q, done_d;

  logic          go_now, load, finish;
  logic [LW:0]   col_sum;

  always_comb begin
    nx_src_d = nx_src_q;  nx_dst_d = nx_dst_q;
    nx_w_d   = nx_w_q;    nx_h_d   = nx_h_q;   nx_k_d = nx_k_q;
    pend_d   = pend_q;
    a_row_d  = a_row_q;   a_dst_d  = a_dst_q;
    a_w_d    = a_w_q;     a_k_d    = a_k_q;
    a_col_d  = a_col_q;   a_rows_d = a_rows_q;
    busy_d   = busy_q;    done_d   = done_q;
    load     = 1'b0;
    go_now   = cfg_we && (cfg_fld == FLD_GO);
    finish   = busy_q && ((a_w_q == '0) || (a_rows_q == '0));
    col_sum  = {1'b0, a_col_q} + (LW+1)'(adv_len);

    if (cfg_we) begin
      case (cfg_fld)
        FLD_SRC: nx_src_d = cfg_wdata;
        FLD_DST: nx_dst_d = cfg_wdata;
        FLD_WID: nx_w_d   = cfg_wdata[LW-1:0];
        FLD_HGT: nx_h_d   = cfg_wdata[LW-1:0];
        FLD_SKP: nx_k_d   = cfg_wdata[LW-1:0];
        FLD_ACK: done_d   = 1'b0;
        default: ;
      endcase
    end

    if (finish) begin
      if (pend_q || go_now) begin
        load   = 1'b1;
        pend_d = 1'b0;
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (go_now) begin
      if (!busy_q) load = 1'b1;
      else         pend_d = 1'b1;
    end

    if (adv) begin
      a_dst_d = a_dst_q + AW'(adv_len);
      if (col_sum == {1'b0, a_w_q}) begin
        a_col_d  = '0;
        a_row_d  = a_row_q + AW'(a_w_q) + AW'(a_k_q);
        a_rows_d = a_rows_q - 1'b1;
      end else begin
        a_col_d  = col_sum[LW-1:0];
      end
    end

    if (load) begin
      a_row_d  = nx_src_q;
      a_dst_d  = nx_dst_q;
      a_w_d    = nx_w_q;
      a_k_d    = nx_k_q;
      a_rows_d = nx_h_q;
      a_col_d  = '0;
      busy_d   = 1'b1;
      done_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nx_src_q <= '0; nx_dst_q <= '0; nx_w_q <= '0; nx_h_q <= '0; nx_k_q <= '0;
      pend_q   <= 1'b0;
      a_row_q  <= '0; a_dst_q  <= '0; a_w_q  <= '0; a_k_q  <= '0;
      a_col_q  <= '0; a_rows_q <= '0;
      busy_q   <= 1'b0; done_q <= 1'b0;
    end else begin
      nx_src_q <= nx_src_d; nx_dst_q <= nx_dst_d;
      nx_w_q   <= nx_w_d;   nx_h_q   <= nx_h_d;   nx_k_q <= nx_k_d;
      pend_q   <= pend_d;
      a_row_q  <= a_row_d;  a_dst_q  <= a_dst_d;
      a_w_q    <= a_w_d;    a_k_q    <= a_k_d;
      a_col_q  <= a_col_d;  a_rows_q <= a_rows_d;
      busy_q   <= busy_d;   done_q   <= done_d;
    end
  end

  assign req     = busy_q && (a_w_q != '0) && (a_rows_q != '0);
  assign rd_addr = a_row_q + AW'(a_col_q);
  assign wr_addr = a_dst_q;
  assign row_rem = a_w_q - a_col_q;
  assign busy    = busy_q;
  assign done    = done_q;

  // R4
  adv_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (req && (({1'b0, a_col_q} + (LW+1)'(adv_len)) <= {1'b0, a_w_q})));

  // R6
  fell_busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R8
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_q);

endmodule

// File: rtl/dma2d_rr_arb.sv
module dma2d_rr_arb #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_vld,
  output logic [CW-1:0] gnt_idx
);

  logic [CW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      automatic int c = (int'(ptr_q) + k) % N;
      if (!gnt_vld && req[c]) begin
        gnt_vld = 1'b1;
        gnt_idx = CW'(c);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take) ptr_d = CW'((int'(gnt_idx) + 1) % N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5
  take_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gnt_vld && req[gnt_idx]));

endmodule

// File: rtl/dma2d_stage_buf.sv
module dma2d_stage_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/dma2d_top.sv
module dma2d_top
  import dma2d_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LW    = 8,
  parameter int BURST = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [2:0]             cfg_fld,
  input  logic [AW-1:0]          cfg_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  output logic [NCH-1:0]         ch_busy,
  output logic [NCH-1:0]         ch_done,
  output logic                   irq
);

  localparam int CW  = $clog2(NCH);
  localparam int BLW = $clog2(BURST + 1);
  localparam int BIW = $clog2(BURST);

  logic [NCH-1:0] req_v, adv_v;
  logic [AW-1:0]  rd_addr_a [NCH];
  logic [AW-1:0]  wr_addr_a [NCH];
  logic [LW-1:0]  row_rem_a [NCH];

  eng_st_e        st_q, st_d;
  logic [CW-1:0]  gch_q, gch_d;
  logic [BLW-1:0] len_q, len_d, idx_q, idx_d;
  logic [AW-1:0]  rbase_q, rbase_d, wbase_q, wbase_d;
  logic           cap_v_q;
  logic [BIW-1:0] cap_i_q;

  logic           take, gnt_vld;
  logic [CW-1:0]  gnt_idx;
  logic [LW-1:0]  rem_g;
  logic [DW-1:0]  buf_rdata;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma2d_chan #(.AW(AW), .LW(LW), .BLW(BLW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && (cfg_ch == CW'(g))),
      .cfg_fld  (cfg_fld),
      .cfg_wdata(cfg_wdata),
      .adv      (adv_v[g]),
      .adv_len  (len_q),
      .req      (req_v[g]),
      .rd_addr  (rd_addr_a[g]),
      .wr_addr  (wr_addr_a[g]),
      .row_rem  (row_rem_a[g]),
      .busy     (ch_busy[g]),
      .done     (ch_done[g])
    );
  end

  dma2d_rr_arb #(.N(NCH), .CW(CW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_v),
    .take   (take),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx)
  );

  dma2d_stage_buf #(.DEPTH(BURST), .DW(DW), .IW(BIW)) u_buf (
    .clk  (clk),
    .we   (cap_v_q),
    .waddr(cap_i_q),
    .wdata(mem_rdata),
    .raddr(idx_q[BIW-1:0]),
    .rdata(buf_rdata)
  );

  assign rem_g = row_rem_a[gnt_idx];

  always_comb begin
    st_d     = st_q;
    gch_d    = gch_q;
    len_d    = len_q;
    idx_d    = idx_q;
    rbase_d  = rbase_q;
    wbase_d  = wbase_q;
    take     = 1'b0;
    adv_v    = '0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (st_q)
      ST_IDLE: begin
        if (gnt_vld) begin
          take    = 1'b1;
          gch_d   = gnt_idx;
          len_d   = (rem_g > LW'(BURST)) ? BLW'(BURST) : BLW'(rem_g);
          rbase_d = rd_addr_a[gnt_idx];
          wbase_d = wr_addr_a[gnt_idx];
          idx_d   = '0;
          st_d    = ST_RD;
        end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = rbase_q + AW'(idx_q);
        if (idx_q == len_q - 1'b1) begin
          idx_d = '0;
          st_d  = ST_DRAIN;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DRAIN: st_d = ST_WR;
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = wbase_q + AW'(idx_q);
        if (idx_q == len_q - 1'b1) begin
          idx_d = '0;
          st_d  = ST_ADV;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_ADV: begin
        adv_v[gch_q] = 1'b1;
        st_d         = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign mem_wdata = buf_rdata;
  assign irq       = |ch_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gch_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      rbase_q <= '0;
      wbase_q <= '0;
      cap_v_q <= 1'b0;
      cap_i_q <= '0;
    end else begin
      st_q    <= st_d;
      gch_q   <= gch_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      rbase_q <= rbase_d;
      wbase_q <= wbase_d;
      cap_v_q <= (st_q == ST_RD);
      cap_i_q <= idx_q[BIW-1:0];
    end
  end

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> ((len_q != '0) && (len_q <= BLW'(BURST))));

  // R4
  wr_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WR) && ($past(st_q) != ST_WR)) |-> ($past(st_q) == ST_DRAIN));

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v_q |-> $past(mem_req && !mem_we));

endmodule

// File: tb/tb_dma2d_top.sv
module tb_dma2d_top;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 32;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_ch;
  logic [2:0]    cfg_fld;
  logic [AW-1:0] cfg_wdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NCH-1:0] ch_busy, ch_done;
  logic          irq;

  int checks, errors;
  int qa [NCH][$];
  int qd [NCH][$];
  int req_cnt, burst_cnt, run_len, max_run;
  int owner [$];
  int early_done;
  logic prev_wr;
  logic [DW-1:0] mem [4096];

  dma2d_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ch_busy(ch_busy), .ch_done(ch_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] pat(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction

  // R10: read data appears the cycle after the request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  task automatic chk(string rq, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every destination write
  always @(negedge clk) begin
    logic wr;
    int hit;
    wr = mem_req && mem_we;
    if (mem_req) req_cnt++;
    if (wr && !prev_wr) begin burst_cnt++; run_len = 0; end
    if (wr) begin
      run_len++;
      if (run_len > max_run) max_run = run_len;
      hit = -1;
      for (int c = 0; c < NCH; c++)
        if (hit < 0 && qa[c].size() > 0 && qa[c][0] == int'(mem_addr)) hit = c;
      if (hit < 0) begin
        chk("R3 unexpected write address", 1'b0, int'(mem_addr), -1);
      end else begin
        chk("R2 R3 written data", mem_wdata == 32'(qd[hit][0]), int'(mem_wdata), qd[hit][0]);
        if (!prev_wr) owner.push_back(hit);
        if (ch_done[hit]) early_done++;
        void'(qa[hit].pop_front());
        void'(qd[hit].pop_front());
      end
    end
    prev_wr = wr;
  end

  // R9 field codes: 0 src 1 dst 2 width 3 height 4 skip 5 go 6 ack
  task automatic wr_reg(int ch, int fld, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_fld = 3'(fld); cfg_wdata = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_desc(int ch, int s, int d, int w, int h, int k);
    wr_reg(ch, 0, s); wr_reg(ch, 1, d); wr_reg(ch, 2, w);
    wr_reg(ch, 3, h); wr_reg(ch, 4, k);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        qa[ch].push_back(d + r*w + c);
        qd[ch].push_back(int'(pat(s + r*(w+k) + c)));
      end
  endtask

  task automatic wait_done(int ch);
    int t = 0;
    while (!ch_done[ch] && t < 5000) begin @(negedge clk); t++; end
    chk("R6 done within time", ch_done[ch], int'(ch_done[ch]), 1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    finish_run();
  end

  initial begin
    int r0, b0;
    checks = 0; errors = 0; req_cnt = 0; burst_cnt = 0; run_len = 0; max_run = 0;
    early_done = 0; prev_wr = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    cfg_we = 1'b0; cfg_ch = '0; cfg_fld = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", !mem_req, int'(mem_req), 0);
    chk("R1 busy", ch_busy == '0, int'(ch_busy), 0);
    chk("R1 done irq", ch_done == '0 && !irq, int'(ch_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 strided block, width not a burst multiple
    b0 = burst_cnt;
    set_desc(0, 'h100, 'h800, 10, 3, 5);
    wr_reg(0, 5, 0);
    wait_done(0);
    chk("R4 bursts per 10x3 block", burst_cnt - b0 == 6, burst_cnt - b0, 6);
    chk("R4 max burst length", max_run <= 8, max_run, 8);
    chk("R3 all words written", qa[0].size() == 0, qa[0].size(), 0);
    chk("R6 busy cleared", !ch_busy[0], int'(ch_busy[0]), 0);
    chk("R6 irq raised", irq, int'(irq), 1);
    chk("R3 packed destination end", mem['h800 + 29] == pat('h100 + 2*15 + 9),
        int'(mem['h800 + 29]), int'(pat('h100 + 39)));

    // R6 R9 ack clears done and irq
    wr_reg(0, 6, 0);
    @(negedge clk);
    chk("R6 ack clears done", !ch_done[0], int'(ch_done[0]), 0);
    chk("R6 irq falls", !irq, int'(irq), 0);

    // R7 zero width and zero height
    r0 = req_cnt;
    wr_reg(1, 2, 0); wr_reg(1, 3, 4); wr_reg(1, 5, 0);
    wr_reg(2, 2, 5); wr_reg(2, 3, 0); wr_reg(2, 5, 0);
    repeat (4) @(negedge clk);
    chk("R7 zero width done", ch_done[1] && !ch_busy[1], int'(ch_done[1]), 1);
    chk("R7 zero height done", ch_done[2] && !ch_busy[2], int'(ch_done[2]), 1);
    chk("R7 no memory request", req_cnt == r0, req_cnt - r0, 0);
    wr_reg(1, 6, 0); wr_reg(2, 6, 0);

    // R5 round robin between two channels with three bursts each
    owner.delete();
    set_desc(0, 'h200, 'h900, 24, 1, 0);
    set_desc(1, 'h300, 'hA00, 24, 1, 0);
    wr_reg(0, 5, 0);
    wr_reg(1, 5, 0);
    wait_done(0);
    wait_done(1);
    chk("R5 burst count", owner.size() == 6, owner.size(), 6);
    for (int i = 0; i < 6 && i < owner.size(); i++)
      chk("R5 alternating grant", owner[i] == (i % 2), owner[i], i % 2);
    wr_reg(0, 6, 0); wr_reg(1, 6, 0);

    // R8 chained descriptor on channel 3
    early_done = 0;
    set_desc(3, 'h400, 'hB00, 4, 2, 2);
    wr_reg(3, 5, 0);
    set_desc(3, 'h500, 'hB40, 6, 1, 0);
    wr_reg(3, 5, 0);
    chk("R8 still busy after queueing", ch_busy[3] && !ch_done[3], int'(ch_busy[3]), 1);
    wait_done(3);
    chk("R8 both descriptors moved", qa[3].size() == 0, qa[3].size(), 0);
    chk("R8 no done before chain end", early_done == 0, early_done, 0);
    wr_reg(3, 6, 0);

    // R2 R3 three channels at once: single column, no skip, wide skip
    set_desc(0, 'h600, 'hC00, 1, 5, 3);
    set_desc(1, 'h640, 'hC40, 9, 2, 0);
    set_desc(2, 'h700, 'hC80, 3, 4, 20);
    wr_reg(0, 5, 0); wr_reg(1, 5, 0); wr_reg(2, 5, 0);
    wait_done(0); wait_done(1); wait_done(2);
    for (int c = 0; c < 3; c++)
      chk("R3 concurrent queue drained", qa[c].size() == 0, qa[c].size(), 0);
    chk("R4 burst bound concurrent", max_run <= 8, max_run, 8);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule